// File: doc/BRIEF.md
# Round-Robin ADC Scan Sequencer

This block is the digital sequencer of a general-purpose analog-to-digital converter with up to ten inputs. A programmable divider produces a sample tick. On each tick, when no conversion is outstanding, the sequencer picks the next enabled input in ascending cyclic order and pulses a start strobe towards the converter. All enabled inputs therefore share one conversion rate. When the converter answers with its done strobe and a 12-bit result, the sequencer files the result and raises sticky interrupt flags. Software drives the block through a word-addressed register bus.

In channel mode each result lands in that input's own data register. It is compared against a low and a high threshold, and a separate flag reports each side of the window. In burst mode the results go instead into a 32-entry FIFO whose entries hold only the sample value. This mode is meant for a single enabled input. A flag fires once the fill reaches a programmable level. The sequencer either runs continuously or makes one pass over the enabled inputs per start command.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The channel-enable field is bits [9:0] of CTRL (address 0). Starts go only to enabled inputs, in ascending order from the rotation pointer with wrap-around. A disabled input is skipped within the same tick, so no tick is spent on it. `adc_ch` carries the selected input while `adc_start` is high.
- R2: DIV (address 1, bits [15:0], reset value 3) makes a tick every DIV+1 clocks. `adc_start` is a one-clock pulse issued the clock after a tick, and only when no conversion is outstanding. A tick that arrives while a conversion is outstanding is dropped and is not deferred.
- R3: In channel mode, a done strobe stores the result in DATA[i] (address 8+i), which reads back in bits [11:0]. It also sets flag bit i if IE (address 3) bit i is set.
- R4: THR (address 2) holds the low limit in bits [11:0] (reset 0) and the high limit in bits [27:16] (reset 4095). A result above the high limit sets flag bit 10+i. A result below the low limit sets flag bit 20+i. Each is gated by the matching IE bit.
- R5: FLAGS (address 4) bits are sticky and cleared by writing 1. When a set and a clear meet in the same clock, the set wins. `irq` is the OR of FLAGS AND IE.
- R6: CTRL bit 16 selects continuous scanning. With it clear, writing CTRL with bit 19 set starts one pass from input 0 that converts each enabled input once and then stops.
- R7: Burst mode is CTRL bit 17, and the FIFO write enable is CTRL bit 18. In burst mode a result is pushed into the FIFO only when bit 18 is set. The result carries no input tag, and neither the data registers nor the per-input flags change.
- R8: The FIFO holds 32 samples. A result that arrives while it is full is dropped and sets flag bit 31 (IE-gated). A read of address 6 returns the oldest sample in bits [11:0] and pops it. An empty FIFO reads as 0.
- R9: FCFG (address 5) holds the fill level in bits [5:0] (reset 1) and reads the current count in bits [21:16]. A push that brings the count to at least the level sets flag bit 30 (IE-gated).
- R10: While no input is enabled, no start is issued and, once no conversion is outstanding, no flag changes.
- R11: After reset all registers hold their reset values, FLAGS, IE, CTRL, the FIFO and all data are zero, and `adc_start` and `irq` are low. Reads return data one clock after `bus_rd`, and return 0 when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| adc_start | output | 1 | Conversion start pulse |
| adc_ch | output | 4 | Input selected for the conversion |
| adc_done | input | 1 | Conversion finished |
| adc_result | input | 12 | Conversion result, valid with `adc_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are FIFO overrun and the dropped ticks that happen while a conversion is outstanding. The bench sets the divider to zero, so a tick comes every clock, and uses a converter model with a three-clock latency, so most ticks fall while a conversion is outstanding. It then leaves burst mode running on one input long enough to fill the FIFO past 32 entries before draining it through the bus, reading two entries beyond empty. The single-pass mode is reached by writing the start command with continuous mode off on a sparse enable pattern, so that both the skip and the end of the pass are seen.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
   localparam logic [ADDR_W-1:0] A_DIV  = 5'd1;
   localparam logic [ADDR_W-1:0] A_THR  = 5'd2;
   localparam logic [ADDR_W-1:0] A_IE   = 5'd3;
   localparam logic [ADDR_W-1:0] A_FLAG = 5'd4;
   localparam logic [ADDR_W-1:0] A_FCFG = 5'd5;
   localparam logic [ADDR_W-1:0] A_FIFO = 5'd6;
   localparam int A_DATA0 = 8;
   localparam int B_CONT  = 16;
   localparam int B_BURST = 17;
   localparam int B_FEN   = 18;
   localparam int B_GO    = 19;
   localparam int HI_LSB  = 16;
   localparam int CNT_LSB = 16;
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= tick ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_ch_pick.sv
module adc_ch_pick #(
   parameter int N_CH = 10,
   parameter int CH_W = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] en,
   input  logic [CH_W-1:0] ptr,
   output logic [CH_W-1:0] sel,
   output logic            last
);
   logic found;

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int k = 0; k < N_CH; k++) begin
         int idx;
         idx = int'(ptr) + k;
         if (idx >= N_CH) idx = idx - N_CH;
         if (!found && en[idx]) begin
            found = 1'b1;
            sel   = CH_W'(idx);
         end
      end
      last = 1'b1;
      for (int i = 0; i < N_CH; i++)
         if (en[i] && (i > int'(sel))) last = 1'b0;
   end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
   parameter int DEPTH = 32,
   parameter int W     = 12,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = $clog2(DEPTH);

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("adc_sample_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign dout  = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int N_CH       = 10,
   parameter int RES_W      = 12,
   parameter int FIFO_DEPTH = 32,
   parameter int DIV_W      = 16,
   parameter int DIV_RST    = 3,
   localparam int CH_W      = $clog2(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              adc_start,
   output logic [CH_W-1:0]   adc_ch,
   input  logic              adc_done,
   input  logic [RES_W-1:0]  adc_result,
   output logic              irq
);
   localparam int FC_W  = $clog2(FIFO_DEPTH + 1);
   localparam int FLG_W = 3 * N_CH + 2;
   localparam int I_FTH = 3 * N_CH;
   localparam int I_OVR = 3 * N_CH + 1;

   if (FLG_W > 32) begin : g_bad_nch
      $error("adc_scan_ctrl: flag map needs 3*N_CH+2 <= 32");
   end
   if (RES_W > HI_LSB || DIV_W > 32) begin : g_bad_width
      $error("adc_scan_ctrl: RES_W must fit 16 bits, DIV_W 32 bits");
   end
   if (A_DATA0 + N_CH > (1 << ADDR_W)) begin : g_bad_map
      $error("adc_scan_ctrl: data registers exceed the address space");
   end

   // control state
   logic [N_CH-1:0]  chan_en_q;
   logic             cont_q, burst_q, fen_q;
   logic [DIV_W-1:0] div_q;
   logic [RES_W-1:0] lo_q, hi_q;
   logic [FLG_W-1:0] ie_q, flags_q, set_v, clr_v;
   logic [FC_W-1:0]  fthr_q;
   logic             busy_q, arm_q;
   logic [CH_W-1:0]  cur_q, ptr_q, sel;
   logic             last, tick, issue, cap;
   logic             f_push, f_pop, f_full, f_empty, f_ovr;
   logic [RES_W-1:0] f_dout;
   logic [FC_W-1:0]  f_count;
   logic [31:0]      rd_mux;
   logic [RES_W-1:0] data_arr [N_CH];
   logic             wr_ctrl;

   adc_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

   adc_ch_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
      .en(chan_en_q), .ptr(ptr_q), .sel(sel), .last(last));

   adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W), .CNT_W(FC_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(f_push), .din(adc_result),
      .pop(f_pop), .dout(f_dout), .count(f_count), .full(f_full),
      .empty(f_empty));

   assign issue   = tick & (cont_q | arm_q) & ~busy_q & (|chan_en_q);
   assign cap     = adc_done & busy_q;
   assign f_push  = cap & burst_q & fen_q & ~f_full;
   assign f_ovr   = cap & burst_q & fen_q & f_full;
   assign f_pop   = bus_rd & (bus_addr == A_FIFO) & ~f_empty;
   assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
   assign clr_v   = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[FLG_W-1:0] : '0;
   assign irq     = |(flags_q & ie_q);

   // per-input result registers
   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic [RES_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_q <= '0;
         else if (cap && !burst_q && cur_q == CH_W'(i))
            data_q <= adc_result;
      end
      assign data_arr[i] = data_q;
   end

   // flag events
   always_comb begin
      set_v = '0;
      if (cap && !burst_q) begin
         set_v[int'(cur_q)]          = 1'b1;
         set_v[N_CH + int'(cur_q)]   = (adc_result > hi_q);
         set_v[2*N_CH + int'(cur_q)] = (adc_result < lo_q);
      end
      set_v[I_FTH] = f_push && ((FC_W + 1)'(f_count) + 1'b1 >= {1'b0, fthr_q});
      set_v[I_OVR] = f_ovr;
      set_v = set_v & ie_q;
   end

   // register read mux
   always_comb begin
      int di;
      rd_mux = '0;
      di     = int'(bus_addr) - A_DATA0;
      case (bus_addr)
         A_CTRL: begin
            rd_mux[N_CH-1:0] = chan_en_q;
            rd_mux[B_CONT]   = cont_q;
            rd_mux[B_BURST]  = burst_q;
            rd_mux[B_FEN]    = fen_q;
         end
         A_DIV:  rd_mux[DIV_W-1:0] = div_q;
         A_THR: begin
            rd_mux[RES_W-1:0]         = lo_q;
            rd_mux[HI_LSB +: RES_W]   = hi_q;
         end
         A_IE:   rd_mux[FLG_W-1:0] = ie_q;
         A_FLAG: rd_mux[FLG_W-1:0] = flags_q;
         A_FCFG: begin
            rd_mux[FC_W-1:0]        = fthr_q;
            rd_mux[CNT_LSB +: FC_W] = f_count;
         end
         A_FIFO: rd_mux[RES_W-1:0] = f_empty ? '0 : f_dout;
         default:
            if (di >= 0 && di < N_CH) rd_mux[RES_W-1:0] = data_arr[di];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en_q <= '0;
         cont_q    <= 1'b0;
         burst_q   <= 1'b0;
         fen_q     <= 1'b0;
         div_q     <= DIV_W'(DIV_RST);
         lo_q      <= '0;
         hi_q      <= '1;
         ie_q      <= '0;
         flags_q   <= '0;
         fthr_q    <= FC_W'(1);
         busy_q    <= 1'b0;
         arm_q     <= 1'b0;
         cur_q     <= '0;
         ptr_q     <= '0;
         adc_start <= 1'b0;
         adc_ch    <= '0;
         bus_rdata <= '0;
      end else begin
         adc_start <= issue;
         if (issue) begin
            adc_ch <= sel;
            cur_q  <= sel;
            busy_q <= 1'b1;
            ptr_q  <= last ? '0 : sel + 1'b1;
            if (last && !cont_q) arm_q <= 1'b0;
         end else if (cap) begin
            busy_q <= 1'b0;
         end
         flags_q   <= (flags_q & ~clr_v) | set_v;
         bus_rdata <= bus_rd ? rd_mux : '0;
         if (wr_ctrl) begin
            chan_en_q <= bus_wdata[N_CH-1:0];
            cont_q    <= bus_wdata[B_CONT];
            burst_q   <= bus_wdata[B_BURST];
            fen_q     <= bus_wdata[B_FEN];
            if (bus_wdata[B_GO]) begin
               arm_q <= 1'b1;
               ptr_q <= '0;
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               A_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
               A_THR: begin
                  lo_q <= bus_wdata[RES_W-1:0];
                  hi_q <= bus_wdata[HI_LSB +: RES_W];
               end
               A_IE:   ie_q   <= bus_wdata[FLG_W-1:0];
               A_FCFG: fthr_q <= bus_wdata[FC_W-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int N_CH  = 10,
   parameter int CH_W  = 4,
   parameter int FLG_W = 32,
   parameter int FC_W  = 6,
   parameter int DEPTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adc_start,
   input logic [CH_W-1:0]  adc_ch,
   input logic             adc_done,
   input logic             busy_q,
   input logic [N_CH-1:0]  chan_en_q,
   input logic [FLG_W-1:0] flags_q,
   input logic             bus_wr,
   input logic [4:0]       bus_addr,
   input logic [FC_W-1:0]  f_count
);
   AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start); // R2

   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !adc_done) |=> !adc_start); // R2

   AST_START_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> ((($past(chan_en_q) >> adc_ch) & 1) != 0)); // R1

   AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en_q == '0) |=> !adc_start); // R10

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 5'd4) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      f_count <= FC_W'(DEPTH)); // R8
endmodule

bind adc_scan_ctrl adc_scan_chk #(
   .N_CH(N_CH), .CH_W(CH_W), .FLG_W(FLG_W), .FC_W(FC_W), .DEPTH(FIFO_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_ch(adc_ch),
   .adc_done(adc_done), .busy_q(busy_q), .chan_en_q(chan_en_q),
   .flags_q(flags_q), .bus_wr(bus_wr), .bus_addr(bus_addr), .f_count(f_count)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        adc_start;
   logic [3:0]  adc_ch;
   logic        adc_done = 1'b0;
   logic [11:0] adc_result = '0;
   logic        irq;

   always #2 clk = ~clk;

   adc_scan_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .adc_start(adc_start), .adc_ch(adc_ch), .adc_done(adc_done),
      .adc_result(adc_result), .irq(irq));

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string req = "R11";
   bit    checking = 1'b0;

   // converter model: answers each start after LAT clocks
   int cd = 0, seed = 17;
   always @(negedge clk) begin
      adc_done <= 1'b0;
      if (cd > 0) begin
         cd = cd - 1;
         if (cd == 0) begin
            seed = (seed * 73 + 611) % 4096;
            adc_result <= 12'(seed);
            adc_done   <= 1'b1;
         end
      end
      if (adc_start) cd = LAT;
   end

   // reference model
   int m_cnt, m_div, m_en, m_cont, m_burst, m_fen, m_lo, m_hi, m_thr;
   int m_busy, m_cur, m_ptr, m_arm, m_start, m_ch;
   int m_data [10];
   int mq [$];
   logic [31:0] m_ie, m_fl, m_rd, setv, clrv;
   int tk, iss, cap, res, pushv, sel, lastv, fnd, idx;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_div = 3; m_en = 0; m_cont = 0; m_burst = 0; m_fen = 0;
         m_lo = 0; m_hi = 4095; m_thr = 1; m_ie = 0; m_fl = 0; m_rd = 0;
         m_busy = 0; m_cur = 0; m_ptr = 0; m_arm = 0; m_start = 0; m_ch = 0;
         foreach (m_data[i]) m_data[i] = 0;
         mq.delete();
      end else begin
         tk = (m_cnt >= m_div);
         m_cnt = tk ? 0 : m_cnt + 1;
         iss = tk && (m_cont || m_arm) && !m_busy && (m_en != 0);
         cap = adc_done && m_busy;
         res = int'(adc_result);
         // read path sees pre-edge state
         m_rd = 0;
         if (bus_rd) begin
            case (int'(bus_addr))
               0: m_rd = 32'(m_en) | 32'(m_cont << 16) | 32'(m_burst << 17) | 32'(m_fen << 18);
               1: m_rd = 32'(m_div);
               2: m_rd = 32'(m_lo) | 32'(m_hi << 16);
               3: m_rd = m_ie;
               4: m_rd = m_fl;
               5: m_rd = 32'(m_thr) | 32'(mq.size() << 16);
               6: if (mq.size() > 0) m_rd = 32'(mq[0]);
               default: if (bus_addr >= 8 && bus_addr < 18) m_rd = 32'(m_data[bus_addr - 8]);
            endcase
         end
         setv = 0; pushv = 0;
         if (cap) begin
            if (m_burst) begin
               if (m_fen) begin
                  if (mq.size() >= 32) setv[31] = 1'b1;
                  else begin
                     pushv = 1;
                     if (mq.size() + 1 >= m_thr) setv[30] = 1'b1;
                  end
               end
            end else begin
               m_data[m_cur] = res;
               setv[m_cur] = 1'b1;
               if (res > m_hi) setv[10 + m_cur] = 1'b1;
               if (res < m_lo) setv[20 + m_cur] = 1'b1;
            end
         end
         if (bus_rd && bus_addr == 6 && mq.size() > 0) void'(mq.pop_front());
         if (pushv) mq.push_back(res);
         setv = setv & m_ie;
         clrv = (bus_wr && bus_addr == 4) ? bus_wdata : 32'h0;
         m_fl = (m_fl & ~clrv) | setv;
         if (iss) begin
            fnd = 0; sel = 0;
            for (int k = 0; k < 10; k++) begin
               idx = (m_ptr + k) % 10;
               if (!fnd && m_en[idx]) begin fnd = 1; sel = idx; end
            end
            lastv = 1;
            for (int i = sel + 1; i < 10; i++) if (m_en[i]) lastv = 0;
            m_start = 1; m_ch = sel; m_busy = 1; m_cur = sel;
            m_ptr = lastv ? 0 : sel + 1;
            if (lastv && !m_cont) m_arm = 0;
         end else begin
            m_start = 0;
            if (cap) m_busy = 0;
         end
         if (bus_wr) begin
            case (int'(bus_addr))
               0: begin
                  m_en = int'(bus_wdata[9:0]); m_cont = int'(bus_wdata[16]);
                  m_burst = int'(bus_wdata[17]); m_fen = int'(bus_wdata[18]);
                  if (bus_wdata[19]) begin m_arm = 1; m_ptr = 0; end
               end
               1: m_div = int'(bus_wdata[15:0]);
               2: begin m_lo = int'(bus_wdata[11:0]); m_hi = int'(bus_wdata[27:16]); end
               3: m_ie = bus_wdata;
               5: m_thr = int'(bus_wdata[5:0]);
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && checking) begin
         chk(32'(adc_start), 32'(m_start), "adc_start");
         if (m_start != 0) chk(32'(adc_ch), 32'(m_ch), "adc_ch");
         chk(32'(irq), 32'(|(m_fl & m_ie)), "irq");
         chk(bus_rdata, m_rd, "bus_rdata");
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 5'(a);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dump_all();
      for (int a = 0; a < 18; a++) rd(a);
   endtask

   task automatic finish_run();
      checking = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      checking = 1'b1;
      // reset values
      req = "R11";
      dump_all();
      // continuous scan over a sparse set, window compare
      req = "R1 R2 R3 R4";
      wr(3, 32'hFFFF_FFFF);
      wr(2, (32'd3000 << 16) | 32'd1000);
      wr(1, 32'd0);
      wr(0, (32'd1 << 16) | 32'b10_1000_1001);
      idle(200);
      wr(1, 32'd6);
      idle(150);
      dump_all();
      // sticky flags, write-one-to-clear
      req = "R5";
      wr(4, 32'h0000_00FF);
      rd(4);
      wr(3, 32'h0000_0200);
      idle(40);
      wr(4, 32'hFFFF_FFFF);
      rd(4);
      wr(3, 32'hFFFF_FFFF);
      // single pass
      req = "R6";
      wr(0, 32'd0);
      idle(30);
      wr(4, 32'hFFFF_FFFF);
      wr(1, 32'd0);
      wr(0, (32'd1 << 19) | 32'b10_0010_0100);
      idle(120);
      dump_all();
      wr(0, (32'd1 << 19) | 32'b00_0000_0001);
      idle(40);
      dump_all();
      // nothing enabled
      req = "R10";
      wr(0, 32'd0);
      idle(20);
      wr(4, 32'hFFFF_FFFF);
      idle(80);
      dump_all();
      // burst path
      req = "R7 R8 R9";
      wr(5, 32'd8);
      wr(0, (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 18) | 32'b00_0001_0000);
      idle(60);
      rd(5);
      rd(4);
      idle(250);
      rd(5);
      rd(4);
      wr(0, 32'd0);
      idle(20);
      for (int n = 0; n < 34; n++) rd(6);
      rd(5);
      wr(4, 32'hFFFF_FFFF);
      wr(0, (32'd1 << 16) | (32'd1 << 17) | 32'b00_0001_0000);
      idle(80);
      dump_all();
      wr(0, 32'd0);
      idle(20);
      finish_run();
   end
endmodule